// File: doc/BRIEF.md
# Self-Routing Sort-Then-Route Switch Fabric

This block is an eight-lane, fully pipelined switch fabric that moves a group of data words from input lanes to output lanes in one pass, with no central scheduler. Each input lane presents a word, a valid bit and a binary output-lane tag. A sorting network of two-input compare-exchange cells first orders the active words by tag and pushes idle lanes to the top. A butterfly of 2x2 steering cells then routes each word to its output, using one tag bit per stage. Because the words reach the butterfly sorted and packed onto the lowest lanes, no two words ever collide inside it.

Both the sorter and the router are registered at every stage. For eight lanes there are six sorting stages and three routing stages, so a group shows up on the outputs nine accepted cycles after it enters. A new group can enter on every cycle. Inputs are expected to carry distinct tags. If two active lanes name the same output, the fabric raises an error flag with that group and delivers only the word from the lowest-numbered input lane.

The data path is a valid/ready stream with one shared ready in each direction. A group is taken in on a clock edge where `out_ready` is high. `in_ready` simply mirrors `out_ready`. While `out_ready` is low, every pipeline stage holds, the outputs stay frozen, and whatever is on the inputs is not taken in. The consumer must accept all output lanes together.

Top module: `fab_batcher_banyan`

## Requirements
- R1: While reset is asserted and right after it, every `out_valid` bit and `dup_err` are 0, and no word that entered before reset appears afterwards.
- R2: An active word on input lane i with tag t appears on output lane t (lane t occupies `out_data[t*DW +: DW]`, tag field lane i is `in_tag[i*TW +: TW]`, binary lane number) with unchanged data, exactly 9 accepted cycles after it entered.
- R3: An output lane whose number no active input of that group named shows `out_valid` low.
- R4: When two or more active inputs of a group share a tag, `dup_err` is 1 in that group's output cycle, and only the lowest-numbered such input lane is delivered. Otherwise `dup_err` is 0.
- R5: With `out_ready` held high, one group is accepted every cycle, and consecutive groups come out in order on consecutive cycles.
- R6: While `out_ready` is low, `out_valid`, `out_data` and `dup_err` hold their values, and input groups presented during that time are never delivered.
- R7: `in_ready` equals `out_ready` in every cycle.
- R8: Any mix of active lanes is handled, from no lanes to all eight (a full permutation), including lane 0 alone and lane 7 alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NP | Per-lane word present |
| in_tag | input | NP*TW | Per-lane destination lane number |
| in_data | input | NP*DW | Per-lane data words |
| in_ready | output | 1 | Group is accepted this cycle |
| out_valid | output | NP | Per-output-lane word present |
| out_data | output | NP*DW | Per-output-lane data words |
| out_ready | input | 1 | Consumer takes the output group; pipeline advances |
| dup_err | output | 1 | Group carried a repeated destination |

## Verification
The bench builds the fabric with its defaults, eight lanes and 16-bit words. This gives a three-bit tag, six sorting stages and three routing stages, so every output lane and every latency slot can be checked directly. At that size a full reverse permutation, a scrambled permutation, single words on the first and last lanes, an empty group, sparse groups and groups with repeated tags can all be streamed back to back. In each case the expected output is computed from the input tags. The stall, the mid-flight reset and the dropping of input during a stall are checked against the same nine-stage depth.

// File: rtl/fab_pkg.sv
package fab_pkg;

  // Direction a compare-exchange cell orders its pair
  typedef enum logic {ORDER_UP = 1'b0, ORDER_DOWN = 1'b1} order_e;

  // Number of compare-exchange stages of a bitonic sorter over 2**lg lanes
  function automatic int sort_depth(input int lg);
    return (lg * (lg + 1)) / 2;
  endfunction

  // Flat stage number of merge pass a (1..lg), sub-step b (a..1)
  function automatic int stage_index(input int a, input int b);
    return ((a * (a - 1)) / 2) + (a - b);
  endfunction

endpackage

// File: rtl/fab_dedup.sv
// Input-side winner selection: among active lanes naming the same output,
// the lowest-numbered lane stays active (R4).
module fab_dedup #(
  parameter int NP = 8,
  parameter int TW = 3
) (
  input  logic [NP-1:0]         i_vld,
  input  logic [NP-1:0][TW-1:0] i_tag,
  output logic [NP-1:0]         o_vld,
  output logic                  o_err
);

  logic [NP-1:0] lost;

  for (genvar i = 0; i < NP; i++) begin : g_lane
    logic [NP-1:0] beaten;
    for (genvar j = 0; j < NP; j++) begin : g_peer
      if (j < i) begin : g_lower
        assign beaten[j] = i_vld[j] && (i_tag[j] == i_tag[i]);
      end else begin : g_upper
        assign beaten[j] = 1'b0;
      end
    end
    assign lost[i]  = i_vld[i] && (|beaten);
    assign o_vld[i] = i_vld[i] && !(|beaten);
  end

  assign o_err = |lost;

endmodule

// File: rtl/fab_sort_stage.sv
// One registered stage of the bitonic sorter. Key = {idle, tag}, so idle
// lanes sort above every active one and active words pack low.
module fab_sort_stage
  import fab_pkg::*;
#(
  parameter int NP = 8,
  parameter int TW = 3,
  parameter int DW = 16,
  parameter int K  = 2,   // size of the bitonic block being merged
  parameter int J  = 1    // distance between partner lanes
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NP-1:0]         i_vld,
  input  logic [NP-1:0][TW-1:0] i_tag,
  input  logic [NP-1:0][DW-1:0] i_dat,
  input  logic                  i_err,
  output logic [NP-1:0]         o_vld,
  output logic [NP-1:0][TW-1:0] o_tag,
  output logic [NP-1:0][DW-1:0] o_dat,
  output logic                  o_err
);

  logic [NP-1:0]         n_vld;
  logic [NP-1:0][TW-1:0] n_tag;
  logic [NP-1:0][DW-1:0] n_dat;

  for (genvar i = 0; i < NP; i++) begin : g_cell
    if ((i & J) == 0) begin : g_cmp
      localparam int     P   = i | J;
      localparam order_e DIR = ((i & K) == 0) ? ORDER_UP : ORDER_DOWN;
      logic [TW:0] key_a, key_b;
      logic        swap;
      assign key_a = {~i_vld[i], i_tag[i]};
      assign key_b = {~i_vld[P], i_tag[P]};
      assign swap  = (DIR == ORDER_UP) ? (key_a > key_b) : (key_a < key_b);
      assign n_vld[i] = swap ? i_vld[P] : i_vld[i];
      assign n_tag[i] = swap ? i_tag[P] : i_tag[i];
      assign n_dat[i] = swap ? i_dat[P] : i_dat[i];
      assign n_vld[P] = swap ? i_vld[i] : i_vld[P];
      assign n_tag[P] = swap ? i_tag[i] : i_tag[P];
      assign n_dat[P] = swap ? i_dat[i] : i_dat[P];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld <= '0;
      o_err <= 1'b0;
    end else if (en) begin
      o_vld <= n_vld;
      o_err <= i_err;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      o_tag <= n_tag;
      o_dat <= n_dat;
    end
  end

endmodule

// File: rtl/fab_banyan_stage.sv
// One registered stage of the routing butterfly. Stage S looks at tag bit
// TW-1-S (most significant first): 0 steers to the upper lane of the pair,
// 1 to the lower lane.
module fab_banyan_stage #(
  parameter int NP = 8,
  parameter int TW = 3,
  parameter int DW = 16,
  parameter int S  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NP-1:0]         i_vld,
  input  logic [NP-1:0][TW-1:0] i_tag,
  input  logic [NP-1:0][DW-1:0] i_dat,
  input  logic                  i_err,
  output logic [NP-1:0]         o_vld,
  output logic [NP-1:0][TW-1:0] o_tag,
  output logic [NP-1:0][DW-1:0] o_dat,
  output logic                  o_err
);

  localparam int BIT = TW - 1 - S;
  localparam int D   = 1 << BIT;

  logic [NP-1:0]         n_vld;
  logic [NP-1:0][TW-1:0] n_tag;
  logic [NP-1:0][DW-1:0] n_dat;

  for (genvar i = 0; i < NP; i++) begin : g_cell
    if ((i & D) == 0) begin : g_sw
      localparam int HI = i | D;
      logic lo_up, lo_dn, hi_up, hi_dn;
      assign lo_up = i_vld[i]  && !i_tag[i][BIT];
      assign lo_dn = i_vld[i]  &&  i_tag[i][BIT];
      assign hi_up = i_vld[HI] && !i_tag[HI][BIT];
      assign hi_dn = i_vld[HI] &&  i_tag[HI][BIT];
      assign n_vld[i]  = lo_up | hi_up;
      assign n_tag[i]  = lo_up ? i_tag[i] : i_tag[HI];
      assign n_dat[i]  = lo_up ? i_dat[i] : i_dat[HI];
      assign n_vld[HI] = lo_dn | hi_dn;
      assign n_tag[HI] = hi_dn ? i_tag[HI] : i_tag[i];
      assign n_dat[HI] = hi_dn ? i_dat[HI] : i_dat[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld <= '0;
      o_err <= 1'b0;
    end else if (en) begin
      o_vld <= n_vld;
      o_err <= i_err;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      o_tag <= n_tag;
      o_dat <= n_dat;
    end
  end

endmodule

// File: rtl/fab_batcher_banyan.sv
// Eight-lane (by default) sort-then-route switch fabric, register per stage.
module fab_batcher_banyan
  import fab_pkg::*;
#(
  parameter  int NP = 8,
  parameter  int DW = 16,
  localparam int TW = $clog2(NP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    in_valid,
  input  logic [NP*TW-1:0] in_tag,
  input  logic [NP*DW-1:0] in_data,
  output logic             in_ready,
  output logic [NP-1:0]    out_valid,
  output logic [NP*DW-1:0] out_data,
  input  logic             out_ready,
  output logic             dup_err
);

  localparam int NS  = sort_depth(TW);
  localparam int LAT = NS + TW;

  // whole pipeline advances together when the consumer takes a group (R5, R6)
  logic adv;
  assign adv      = out_ready;
  assign in_ready = out_ready;   // R7

  // sorter lane buses, index 0 is the deduplicated input
  logic [NS:0][NP-1:0]         s_vld;
  logic [NS:0][NP-1:0][TW-1:0] s_tag;
  logic [NS:0][NP-1:0][DW-1:0] s_dat;
  logic [NS:0]                 s_err;

  // router lane buses, index 0 is the sorter output
  logic [TW:0][NP-1:0]         b_vld;
  logic [TW:0][NP-1:0][TW-1:0] b_tag;
  logic [TW:0][NP-1:0][DW-1:0] b_dat;
  logic [TW:0]                 b_err;

  logic [NP-1:0][TW-1:0] tag_in;
  logic [NP-1:0][DW-1:0] dat_in;
  assign tag_in = in_tag;
  assign dat_in = in_data;

  fab_dedup #(.NP(NP), .TW(TW)) u_dedup (
    .i_vld (in_valid),
    .i_tag (tag_in),
    .o_vld (s_vld[0]),
    .o_err (s_err[0])
  );
  assign s_tag[0] = tag_in;
  assign s_dat[0] = dat_in;

  for (genvar a = 1; a <= TW; a++) begin : g_merge
    for (genvar b = a; b >= 1; b--) begin : g_step
      localparam int IDX = stage_index(a, b);
      fab_sort_stage #(
        .NP(NP), .TW(TW), .DW(DW), .K(1 << a), .J(1 << (b - 1))
      ) u_sort (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .i_vld (s_vld[IDX]),
        .i_tag (s_tag[IDX]),
        .i_dat (s_dat[IDX]),
        .i_err (s_err[IDX]),
        .o_vld (s_vld[IDX+1]),
        .o_tag (s_tag[IDX+1]),
        .o_dat (s_dat[IDX+1]),
        .o_err (s_err[IDX+1])
      );
    end
  end

  // Sorted, packed lanes feed the butterfly straight across: a packed run of
  // ascending distinct tags stays a cyclic run in every half, so no cell ever
  // sees both of its inputs asking for the same side.
  assign b_vld[0] = s_vld[NS];
  assign b_tag[0] = s_tag[NS];
  assign b_dat[0] = s_dat[NS];
  assign b_err[0] = s_err[NS];

  for (genvar s = 0; s < TW; s++) begin : g_route
    fab_banyan_stage #(.NP(NP), .TW(TW), .DW(DW), .S(s)) u_route (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .i_vld (b_vld[s]),
      .i_tag (b_tag[s]),
      .i_dat (b_dat[s]),
      .i_err (b_err[s]),
      .o_vld (b_vld[s+1]),
      .o_tag (b_tag[s+1]),
      .o_dat (b_dat[s+1]),
      .o_err (b_err[s+1])
    );
  end

  assign out_valid = b_vld[TW];
  assign out_data  = b_dat[TW];
  assign dup_err   = b_err[TW];

endmodule

// File: rtl/fab_checker.sv
// Port-level checker: tracks per-group delivered count and repeat flag
// along a shadow of the pipeline depth.
module fab_checker #(
  parameter int NP  = 8,
  parameter int TW  = 3,
  parameter int DW  = 16,
  parameter int LAT = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NP-1:0]         in_valid,
  input logic [NP-1:0][TW-1:0] in_tag,
  input logic                  out_ready,
  input logic [NP-1:0]         out_valid,
  input logic [NP*DW-1:0]      out_data,
  input logic                  dup_err
);

  localparam int CW = $clog2(NP + 1);

  logic [CW-1:0]          grp_cnt;
  logic                   grp_dup;
  logic [LAT-1:0][CW-1:0] cnt_sh;
  logic [LAT-1:0]         dup_sh;

  always_comb begin
    logic first;
    grp_cnt = '0;
    grp_dup = 1'b0;
    for (int i = 0; i < NP; i++) begin
      first = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (in_valid[j] && (in_tag[j] == in_tag[i])) first = 1'b0;
      end
      if (in_valid[i]) begin
        if (first) grp_cnt = grp_cnt + 1'b1;
        else       grp_dup = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_sh <= '0;
      dup_sh <= '0;
    end else if (out_ready) begin
      cnt_sh[0] <= grp_cnt;
      dup_sh[0] <= grp_dup;
      for (int k = 1; k < LAT; k++) begin
        cnt_sh[k] <= cnt_sh[k-1];
        dup_sh[k] <= dup_sh[k-1];
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (out_valid == '0) && !dup_err);

  assert_count_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    CW'($countones(out_valid)) == cnt_sh[LAT-1]);

  assert_empty_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_sh[LAT-1] == '0) |-> (out_valid == '0));

  assert_dup_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err == dup_sh[LAT-1]);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(out_valid) && $stable(out_data) && $stable(dup_err));

endmodule

bind fab_batcher_banyan fab_checker #(
  .NP(NP), .TW(TW), .DW(DW), .LAT(LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_tag    (in_tag),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .dup_err   (dup_err)
);

// File: tb/tb_fab_batcher_banyan.sv
module tb_fab_batcher_banyan;

  localparam int NP  = 8;
  localparam int DW  = 16;
  localparam int TW  = 3;
  localparam int LAT = 9;
  localparam int NV  = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP*TW-1:0] in_tag = '0;
  logic [NP*DW-1:0] in_data = '0;
  logic             in_ready;
  logic [NP-1:0]    out_valid;
  logic [NP*DW-1:0] out_data;
  logic             out_ready = 1'b1;
  logic             dup_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  fab_batcher_banyan #(.NP(NP), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .dup_err(dup_err)
  );

  // {active lanes, tags as octal digits lane7..lane0}
  localparam logic [31:0] VEC [NV] = '{
    {8'hff, 24'o76543210},  // identity
    {8'hff, 24'o01234567},  // reverse
    {8'hff, 24'o35170624},  // scrambled permutation
    {8'h01, 24'o00000005},  // lane 0 alone
    {8'h80, 24'o00000000},  // lane 7 alone
    {8'h00, 24'o77777777},  // empty
    {8'ha5, 24'o47377176},  // sparse
    {8'hff, 24'o22222222},  // all same destination
    {8'h0f, 24'o00000353},  // partial repeat
    {8'hfe, 24'o65432107}   // seven lanes
  };

  task automatic drive(input int id, input logic [31:0] vec);
    in_valid = vec[31:24];
    in_tag   = vec[23:0];
    for (int i = 0; i < NP; i++) in_data[i*DW +: DW] = {8'(id), 8'(i)};
  endtask

  task automatic drive_idle();
    in_valid = '0;
    in_tag   = '0;
    in_data  = '0;
  endtask

  task automatic check_grp(input string req, input int id, input logic [31:0] vec);
    logic [NP-1:0]         ev;
    logic [NP-1:0][DW-1:0] ed;
    logic                  ee;
    logic                  ok;
    int                    t;
    ev = '0; ed = '0; ee = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (vec[24+i]) begin
        t = int'(vec[i*TW +: TW]);
        if (ev[t]) ee = 1'b1;
        else begin
          ev[t] = 1'b1;
          ed[t] = {8'(id), 8'(i)};
        end
      end
    end
    ok = (out_valid == ev) && (dup_err == ee);
    for (int o = 0; o < NP; o++)
      if (ev[o] && out_data[o*DW +: DW] != ed[o]) ok = 1'b0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s group %0d: valid=%b data=%h err=%b expected valid=%b data=%h err=%b",
               req, id, out_valid, out_data, dup_err, ev, ed, ee);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_none(input string req);
    total++;
    if (out_valid !== '0 || dup_err !== 1'b0) begin
      bad++;
      $display("FAIL %s: valid=%b err=%b expected valid=0 err=0", req, out_valid, dup_err);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP*DW-1:0] snap_d;
    logic [NP-1:0]    snap_v;
    // R1: outputs idle in reset
    repeat (3) @(negedge clk);
    check_none("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_none("R1 after reset");
    check_bit("R7 ready high", in_ready, 1'b1);

    // R2 R3 R4 R5 R8: table streamed one group per cycle
    for (int t = 0; t < NV + LAT; t++) begin
      @(negedge clk);
      if (t >= LAT) check_grp("R2 R3 R4 R5 R8 stream", t - LAT, VEC[t - LAT]);
      if (t < NV) drive(t, VEC[t]);
      else drive_idle();
    end

    // R6: stall while a group sits on the outputs
    @(negedge clk);
    drive(40, VEC[2]);
    for (int t = 1; t <= LAT; t++) begin
      @(negedge clk);
      if (t == 1) drive_idle();
    end
    check_grp("R2 before stall", 40, VEC[2]);
    out_ready = 1'b0;
    drive(41, VEC[0]);
    snap_d = out_data;
    snap_v = out_valid;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check_bit("R7 ready low in stall", in_ready, 1'b0);
      check_bit("R6 outputs held", (out_data == snap_d) && (out_valid == snap_v), 1'b1);
    end
    check_grp("R6 group kept", 40, VEC[2]);
    out_ready = 1'b1;
    drive_idle();
    for (int t = 0; t < LAT + 1; t++) begin
      @(negedge clk);
      check_none("R6 stalled input dropped");
    end

    // R1: reset mid-flight discards groups in the pipe
    drive(50, VEC[1]);
    @(negedge clk);
    drive(51, VEC[6]);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    drive_idle();
    @(negedge clk);
    check_none("R1 reset mid-flight");
    rst_n = 1'b1;
    for (int t = 0; t < LAT + 1; t++) begin
      @(negedge clk);
      if (t == LAT) check_none("R1 no stale group");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule